// File: doc/BRIEF.md
# Bipolar Zero-Substitution Line Decoder

This block turns a dual-rail bipolar line signal into NRZ data for a DS3 or E3 tributary. Every clock is one bit period. It samples one symbol per clock from a positive-rail input and a negative-rail input: a pulse on one rail, no pulse, or an illegal pulse on both rails. A run-time mode input selects which zero-substitution code is removed. In B3ZS mode three zeros travel as `00V` or `B0V`. In HDB3 mode four zeros travel as `000V` or `B00V`.

A decode-enable input switches substitution removal off, so that plain AMI data passes through with every pulse read as a one. The block reports line code violations and runs of excess zeros on single-cycle pulse outputs. The NRZ stream leaves the block through a fixed four-stage delay. A substitution can therefore be recognised at its violation pulse and still wipe out the pulses that led into it.

Top module: `bp_line_decoder`

## Requirements
- R1: While `rst_n` is low, `nrz_data`, `nrz_valid`, `lcv_pulse` and `exz_pulse` are all 0, and the polarity history, the last-violation memory and the zero-run count are cleared.
- R2: A symbol driven in the cycle that ends at clock edge k is decoded onto `nrz_data` after edge k+3, a latency of four clock periods. `nrz_valid` goes high after the fourth edge following reset release and stays high until the next reset.
- R3: A symbol that is not part of an accepted substitution decodes as 1 if a single rail pulses and as 0 if neither rail pulses.
- R4: With `hdb3_mode`=0 and `dec_en`=1, a violation preceded by two zeros (`00V`) or by a pulse and then one zero (`B0V`) is an accepted substitution. All three of its symbols decode as 0.
- R5: With `hdb3_mode`=1 and `dec_en`=1, a violation preceded by three zeros (`000V`) or by a pulse and then two zeros (`B00V`) is an accepted substitution. All four of its symbols decode as 0.
- R6: A violation is a single-rail pulse with the same polarity as the latest single-rail pulse. It completes a substitution only if its polarity differs from the last accepted substitution violation, or if no substitution has been accepted since reset. A both-rail symbol anywhere in the window prevents acceptance.
- R7: `lcv_pulse` is high for one cycle, after the edge that samples the symbol, for each violation that does not complete an accepted substitution. It is not raised for an accepted one.
- R8: A symbol with both rails high raises `lcv_pulse`, decodes as 1, leaves the polarity history unchanged and ends any zero run.
- R9: `exz_pulse` is high after the edge that samples a zero that brings the current zero run to 3 or more symbols in B3ZS mode, or to 4 or more in HDB3 mode.
- R10: With `dec_en`=0, no substitution is removed. Every single-rail pulse decodes as 1, and every violation raises `lcv_pulse`.
- R11: The first single-rail pulse after reset is never a violation. It decodes as 1 and raises no `lcv_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock, one symbol per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| rx_pos | input | 1 | Positive-rail pulse |
| rx_neg | input | 1 | Negative-rail pulse |
| hdb3_mode | input | 1 | 0 selects B3ZS, 1 selects HDB3 |
| dec_en | input | 1 | 1 removes substitutions, 0 passes AMI through |
| nrz_data | output | 1 | Decoded NRZ bit, four periods behind the line |
| nrz_valid | output | 1 | High once the delay pipe holds real symbols |
| lcv_pulse | output | 1 | Line code violation, one cycle per event |
| exz_pulse | output | 1 | Excess-zero event, one cycle per qualifying zero |

## Verification
A corrupted polarity memory shows up at the very next single-rail pulse. Either `lcv_pulse` fires where it should not, or it stays low for a real violation, one cycle after the edge that samples that pulse. A wrong last-violation memory, or a wrong window of earlier symbols, shows up in two places. The substitution either survives as ones or eats real data on `nrz_data` up to four cycles later, and the same violation also changes `lcv_pulse`. A miscounted zero run moves `exz_pulse` by the error in the count on the very zero that should have qualified. The bench runs a behavioural model alongside the block and compares all four outputs on every clock, so any such fault is reported within the latency given in R2.

// File: rtl/bp_line_pkg.sv
package bp_line_pkg;

  // Symbol seen on the two rails in one bit period: {neg, pos}
  typedef enum logic [1:0] {
    SYM_ZERO = 2'b00,
    SYM_POS  = 2'b01,
    SYM_NEG  = 2'b10,
    SYM_BOTH = 2'b11
  } sym_t;

  // Number of symbols covered by one substitution code
  localparam int B3ZS_LEN = 3;
  localparam int HDB3_LEN = 4;

  // Longest code, sets delay and history depth
  localparam int MAX_SUB_LEN = (HDB3_LEN > B3ZS_LEN) ? HDB3_LEN : B3ZS_LEN;

endpackage

// File: rtl/bp_rail_class.sv
module bp_rail_class
  import bp_line_pkg::*;
(
  input  logic pos_i,
  input  logic neg_i,
  output sym_t sym_o
);

  always_comb begin
    unique case ({neg_i, pos_i})
      2'b00:   sym_o = SYM_ZERO;
      2'b01:   sym_o = SYM_POS;
      2'b10:   sym_o = SYM_NEG;
      default: sym_o = SYM_BOTH;
    endcase
  end

endmodule

// File: rtl/bp_sub_detect.sv
module bp_sub_detect
  import bp_line_pkg::*;
#(
  parameter int HIST = MAX_SUB_LEN - 1
)(
  input  logic            clk,
  input  logic            rst_n,
  input  sym_t            sym_i,
  input  logic            hdb3_i,
  input  logic            dec_en_i,
  output logic            accept_o,
  output logic            lcv_o,
  output logic [HIST-1:0] clr_o
);

  // hist_q[0] is the previous symbol, hist_q[HIST-1] the oldest one kept
  sym_t hist_q [HIST];
  sym_t hist_d [HIST];

  logic pol_vld_q, pol_vld_d;   // a single-rail pulse has been seen
  logic pol_neg_q, pol_neg_d;   // polarity of that pulse
  logic v_vld_q,   v_vld_d;     // a substitution has been accepted
  logic v_neg_q,   v_neg_d;     // polarity of its violation

  logic single, cur_neg, viol, win_b3, win_hd, win_ok, alt_ok;
  int   sub_len;

  always_comb begin
    single  = (sym_i == SYM_POS) || (sym_i == SYM_NEG);
    cur_neg = (sym_i == SYM_NEG);
    viol    = single && pol_vld_q && (cur_neg == pol_neg_q);

    win_b3  = (hist_q[0] == SYM_ZERO) && (hist_q[1] != SYM_BOTH);
    win_hd  = (hist_q[0] == SYM_ZERO) && (hist_q[1] == SYM_ZERO) &&
              (hist_q[2] != SYM_BOTH);
    win_ok  = hdb3_i ? win_hd : win_b3;
    alt_ok  = !v_vld_q || (cur_neg != v_neg_q);

    accept_o = dec_en_i && viol && win_ok && alt_ok;
    lcv_o    = (sym_i == SYM_BOTH) || (viol && !accept_o);

    sub_len = hdb3_i ? HDB3_LEN : B3ZS_LEN;
    for (int i = 0; i < HIST; i++) begin
      clr_o[i] = accept_o && (i < sub_len - 1);
    end

    hist_d[0] = sym_i;
    for (int i = 1; i < HIST; i++) begin
      hist_d[i] = hist_q[i-1];
    end

    pol_vld_d = pol_vld_q | single;
    pol_neg_d = single ? cur_neg : pol_neg_q;
    v_vld_d   = v_vld_q | accept_o;
    v_neg_d   = accept_o ? cur_neg : v_neg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < HIST; i++) begin
        hist_q[i] <= SYM_ZERO;
      end
      pol_vld_q <= 1'b0;
      pol_neg_q <= 1'b0;
      v_vld_q   <= 1'b0;
      v_neg_q   <= 1'b0;
    end else begin
      for (int i = 0; i < HIST; i++) begin
        hist_q[i] <= hist_d[i];
      end
      pol_vld_q <= pol_vld_d;
      pol_neg_q <= pol_neg_d;
      v_vld_q   <= v_vld_d;
      v_neg_q   <= v_neg_d;
    end
  end

endmodule

// File: rtl/bp_zero_run.sv
module bp_zero_run
  import bp_line_pkg::*;
#(
  parameter int MAXLEN = MAX_SUB_LEN
)(
  input  logic clk,
  input  logic rst_n,
  input  sym_t sym_i,
  input  logic hdb3_i,
  output logic exz_o
);

  localparam int RUN_W = $clog2(MAXLEN + 1);

  logic [RUN_W-1:0] run_q, run_d, thr;

  always_comb begin
    if (sym_i != SYM_ZERO) begin
      run_d = '0;
    end else if (run_q == RUN_W'(MAXLEN)) begin
      run_d = run_q;
    end else begin
      run_d = run_q + 1'b1;
    end
    thr   = hdb3_i ? RUN_W'(HDB3_LEN) : RUN_W'(B3ZS_LEN);
    exz_o = (sym_i == SYM_ZERO) && (run_d >= thr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else begin
      run_q <= run_d;
    end
  end

endmodule

// File: rtl/bp_nrz_pipe.sv
module bp_nrz_pipe #(
  parameter int DEPTH = 4
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_i,
  input  logic [DEPTH-2:0] clr_i,
  output logic             data_o,
  output logic             valid_o
);

  logic [DEPTH-1:0] pipe_q, pipe_d;
  logic [DEPTH-1:0] vld_q,  vld_d;

  always_comb begin
    pipe_d[0] = bit_i;
    for (int i = 1; i < DEPTH; i++) begin
      pipe_d[i] = pipe_q[i-1] & ~clr_i[i-1];
    end
    vld_d = {vld_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
      vld_q  <= '0;
    end else begin
      pipe_q <= pipe_d;
      vld_q  <= vld_d;
    end
  end

  assign data_o  = pipe_q[DEPTH-1];
  assign valid_o = vld_q[DEPTH-1];

endmodule

// File: rtl/bp_line_decoder.sv
module bp_line_decoder
  import bp_line_pkg::*;
#(
  parameter int PIPE_DEPTH = MAX_SUB_LEN
)(
  input  logic clk,
  input  logic rst_n,
  input  logic rx_pos,
  input  logic rx_neg,
  input  logic hdb3_mode,
  input  logic dec_en,
  output logic nrz_data,
  output logic nrz_valid,
  output logic lcv_pulse,
  output logic exz_pulse
);

  localparam int HIST = PIPE_DEPTH - 1;

  sym_t            sym;
  logic            sub_accept;
  logic            lcv_d, exz_d, dec_bit;
  logic [HIST-1:0] sub_clr;
  logic            lcv_q, exz_q;

  bp_rail_class u_class (
    .pos_i (rx_pos),
    .neg_i (rx_neg),
    .sym_o (sym)
  );

  bp_sub_detect #(.HIST(HIST)) u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .sym_i    (sym),
    .hdb3_i   (hdb3_mode),
    .dec_en_i (dec_en),
    .accept_o (sub_accept),
    .lcv_o    (lcv_d),
    .clr_o    (sub_clr)
  );

  bp_zero_run #(.MAXLEN(MAX_SUB_LEN)) u_zrun (
    .clk    (clk),
    .rst_n  (rst_n),
    .sym_i  (sym),
    .hdb3_i (hdb3_mode),
    .exz_o  (exz_d)
  );

  assign dec_bit = (sym != SYM_ZERO) && !sub_accept;

  bp_nrz_pipe #(.DEPTH(PIPE_DEPTH)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_i   (dec_bit),
    .clr_i   (sub_clr),
    .data_o  (nrz_data),
    .valid_o (nrz_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcv_q <= 1'b0;
      exz_q <= 1'b0;
    end else begin
      lcv_q <= lcv_d;
      exz_q <= exz_d;
    end
  end

  assign lcv_pulse = lcv_q;
  assign exz_pulse = exz_q;

endmodule

// File: rtl/bp_line_decoder_chk.sv
module bp_line_decoder_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_pos,
  input logic rx_neg,
  input logic dec_en,
  input logic nrz_data,
  input logic nrz_valid,
  input logic lcv_pulse,
  input logic exz_pulse,
  input logic accept
);

  // R1: outputs quiet while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (!nrz_data && !nrz_valid && !lcv_pulse && !exz_pulse)
        else $error("R1 outputs active during reset");
    end
  end

  // R2: once valid, stays valid
  a_r2_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    nrz_valid |=> nrz_valid);

  // R7: an accepted substitution raises no violation
  a_r7_accept_no_lcv: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !lcv_pulse);

  // R8: both rails at once is always a violation
  a_r8_both_rails_lcv: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pos && rx_neg) |=> lcv_pulse);

  // R9: an excess-zero event only follows a zero symbol
  a_r9_exz_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    exz_pulse |-> $past(!rx_pos && !rx_neg));

  // R9: an event cannot be both a zero and a violation
  a_r9_exz_lcv_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(exz_pulse && lcv_pulse));

  // R10: with decoding off, a single-rail pulse emerges as a one
  a_r10_ami_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (nrz_valid && $past(!dec_en, 1) && $past(!dec_en, 2) && $past(!dec_en, 3) &&
     $past(!dec_en, 4) && $past(rx_pos ^ rx_neg, 4)) |-> nrz_data);

endmodule

bind bp_line_decoder bp_line_decoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_pos    (rx_pos),
  .rx_neg    (rx_neg),
  .dec_en    (dec_en),
  .nrz_data  (nrz_data),
  .nrz_valid (nrz_valid),
  .lcv_pulse (lcv_pulse),
  .exz_pulse (exz_pulse),
  .accept    (sub_accept)
);

// File: tb/sim_bp_line_decoder.sv
module sim_bp_line_decoder;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, rx_pos, rx_neg, hdb3_mode, dec_en;
  logic nrz_data, nrz_valid, lcv_pulse, exz_pulse;

  bp_line_decoder u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_pos    (rx_pos),
    .rx_neg    (rx_neg),
    .hdb3_mode (hdb3_mode),
    .dec_en    (dec_en),
    .nrz_data  (nrz_data),
    .nrz_valid (nrz_valid),
    .lcv_pulse (lcv_pulse),
    .exz_pulse (exz_pulse)
  );

  int    checks = 0;
  int    errors = 0;
  string req = "R1";

  // Behavioural model. Symbols: 0 none, +1 pos, -1 neg, 2 both rails.
  int m_hist[$];
  int m_bits[$];
  int m_lastpol, m_lastv, m_run, m_k;
  logic e_data, e_valid, e_lcv, e_exz;

  task automatic chk(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_hist = '{0, 0, 0};
    m_bits = {};
    m_lastpol = 0; m_lastv = 0; m_run = 0; m_k = 0;
    e_data = 0; e_valid = 0; e_lcv = 0; e_exz = 0;
  endtask

  task automatic model_step(int sym);
    int   n;
    logic viol, win, alt, acc;
    n    = hdb3_mode ? 4 : 3;
    viol = (sym == 1 || sym == -1) && (m_lastpol != 0) && (sym == m_lastpol);
    if (n == 3) win = (m_hist[0] == 0) && (m_hist[1] != 2);
    else        win = (m_hist[0] == 0) && (m_hist[1] == 0) && (m_hist[2] != 2);
    alt = (m_lastv == 0) || (sym != m_lastv);
    acc = dec_en && viol && win && alt;
    m_bits.push_back((acc || sym == 0) ? 0 : 1);
    if (acc) begin
      for (int j = 1; j < n; j++) begin
        if (m_k - j >= 0) m_bits[m_k - j] = 0;
      end
    end
    e_lcv = (sym == 2) || (viol && !acc);
    m_run = (sym == 0) ? m_run + 1 : 0;
    e_exz = (sym == 0) && (m_run >= n);
    if (sym == 1 || sym == -1) m_lastpol = sym;
    if (acc) m_lastv = sym;
    m_hist.push_front(sym);
    void'(m_hist.pop_back());
    e_valid = (m_k >= 3);
    e_data  = (m_k >= 3) ? m_bits[m_k - 3][0] : 1'b0;
    m_k++;
  endtask

  task automatic step(int sym);
    rx_pos = (sym == 1) || (sym == 2);
    rx_neg = (sym == -1) || (sym == 2);
    @(posedge clk);
    model_step(sym);
    @(negedge clk);
    chk("nrz_data",  nrz_data,  e_data);
    chk("nrz_valid", nrz_valid, e_valid);
    chk("lcv_pulse", lcv_pulse, e_lcv);
    chk("exz_pulse", exz_pulse, e_exz);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; rx_pos = 0; rx_neg = 0;
    model_reset();
    @(negedge clk);
    req = "R1";
    chk("nrz_data",  nrz_data,  1'b0);
    chk("nrz_valid", nrz_valid, 1'b0);
    chk("lcv_pulse", lcv_pulse, 1'b0);
    chk("exz_pulse", exz_pulse, 1'b0);
    rst_n = 1;
  endtask

  task automatic flush();
    for (int i = 0; i < 5; i++) step(1 - 2 * (i % 2));
  endtask

  task automatic seq(int s[]);
    foreach (s[i]) step(s[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; rx_pos = 0; rx_neg = 0; hdb3_mode = 0; dec_en = 1;
    do_reset();

    // R11 and R2: first pulse repeats a "polarity" only against nothing
    req = "R11"; step(1);
    req = "R2";  seq('{0, -1, 1, 0});

    // R3: plain alternate mark inversion
    req = "R3"; seq('{1, 0, -1, 0, 0, 1, -1});
    flush();

    // R4: B3ZS 00V then B0V with alternating violations
    do_reset(); hdb3_mode = 0; req = "R4";
    seq('{1, 0, 0, 1, -1, 0, -1, 1, 0, 0, 1});
    flush();

    // R5: HDB3 000V then B00V
    do_reset(); hdb3_mode = 1; req = "R5";
    seq('{-1, 0, 0, 0, -1, 1, 0, 0, 1, -1, 0, 0, 0, -1});
    flush();

    // R6: second violation repeats the last substitution polarity
    do_reset(); hdb3_mode = 1; req = "R6";
    seq('{1, 0, 0, 0, 1, 0, 0, 0, 1, -1, 2, 0, -1});
    flush();

    // R7: violation outside any substitution window
    do_reset(); hdb3_mode = 0; req = "R7";
    seq('{1, 1, -1, -1, -1});
    flush();

    // R8: both rails, polarity history untouched
    do_reset(); req = "R8";
    seq('{1, 2, -1, 0, 2, 0, 1});
    flush();

    // R9: long zero runs in each mode
    do_reset(); hdb3_mode = 0; req = "R9";
    seq('{1, 0, 0, 0, 0, 0, -1, 0, 0});
    hdb3_mode = 1;
    seq('{0, 0, 0, 0, 0, 1});
    flush();

    // R10: decoding disabled, substitutions pass as ones
    do_reset(); dec_en = 0; req = "R10";
    seq('{1, 0, 0, 1, -1, 0, -1, 0, 0});
    hdb3_mode = 1;
    seq('{1, 0, 0, 0, 1, 0});
    flush();
    dec_en = 1;

    // Mixed traffic across modes and enable settings
    do_reset(); req = "R3";
    for (int i = 0; i < 4000; i++) begin
      int r, s;
      if (i % 500 == 0) hdb3_mode = ~hdb3_mode;
      if (i % 700 == 0) dec_en = ($urandom % 4) != 0;
      r = $urandom % 16;
      if (r < 7) s = 0;
      else if (r < 11) s = 1;
      else if (r < 15) s = -1;
      else s = 2;
      step(s);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule